// File: doc/BRIEF.md
# Character Display Address Counter Unit

This block is the command and address-counter core of a character display controller. A host drives a register-select line, a read/write line, an 8-bit data byte and an enable strobe. The block takes each transfer on the falling edge of the enable strobe and brings it into the core clock domain. It then loads, steps or reports one shared address counter. Data bytes go to either a 64-byte glyph-pattern RAM or a 128-location character-code RAM through two registered write ports.

The counter has two address spaces. After a glyph-RAM address load, only six bits are live and the count wraps between 3FH and 00H. After a character-RAM address load, the counter covers two display rows of 40 cells each, at 00H–27H and 40H–67H. Stepping up from the last cell of a row lands on the first cell of the next row. Stepping down does the reverse. The direction is held in an entry-direction register. A host status read returns the counter value with a busy bit that is always clear.

Top module: `char_ac_core`

## Requirements
- R1: After reset, the counter is 00H, the target is the character RAM, the direction is increment, and neither write strobe is high.
- R2: A transfer with RS=0, R/W=0 and data[7:6]=01 loads data[5:0] into the counter and selects the glyph RAM.
- R3: While the glyph RAM is selected, bit 6 of the readback is 0. A step up from 3FH gives 00H, and a step down from 00H gives 3FH.
- R4: A transfer with RS=0, R/W=0 and data[7]=1 loads data[6:0] into the counter and selects the character RAM.
- R5: While the character RAM is selected, a step up goes from 27H to 40H and from 67H to 00H. A step down goes from 40H to 27H and from 00H to 67H. Any other step is plus or minus one.
- R6: With RS=0 and R/W=1, host_dout carries the busy bit (always 0) on bit 7 and the 7-bit counter on bits 6:0.
- R7: A transfer with RS=1 and R/W=0 writes the data byte to the current counter address in the selected RAM. The write raises only that RAM's strobe.
- R8: After each data write, the counter steps once in the current direction.
- R9: A transfer with RS=0, R/W=0 and data[7:2]=000001 sets the direction: data[1]=1 means increment and data[1]=0 means decrement.
- R10: Transfers with RS=1 and R/W=1, with RS=0 and R/W=1, and with RS=0, R/W=0 and any other data[7:6]=00 pattern leave the counter, the target and the direction unchanged.
- R11: A transfer acts only after the enable strobe falls. Each data write raises its strobe for exactly one core cycle. The address and data outputs hold their values until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host enable strobe; a transfer is taken on its falling edge |
| host_rs | input | 1 | Register select: 0 command/status, 1 data |
| host_rw | input | 1 | 1 read, 0 write |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Status readback: busy bit and counter |
| cg_we | output | 1 | Glyph RAM write strobe |
| cg_addr | output | 6 | Glyph RAM write address |
| cg_wdata | output | 8 | Glyph RAM write data |
| dd_we | output | 1 | Character RAM write strobe |
| dd_addr | output | 7 | Character RAM write address |
| dd_wdata | output | 8 | Character RAM write data |

## Verification
The bench targets the four row-boundary jumps in both directions. A design that did only plain binary stepping would write into the unused 28H–3FH or 68H–7FH holes. The bench runs more than 64 glyph writes to show that the six-bit count wraps and never sets bit 6. If the counter were wider, a write would land in a cell that does not exist. The bench also sends command bytes that are close to valid codes, and a data read. A loose decoder would change direction or target on these, and a later write would then land at the wrong address. A reset in the middle of glyph mode must put the target back to the character RAM, set the direction to increment and clear the counter.

// File: rtl/char_ac_pkg.sv
`timescale 1ns/1ps
package char_ac_pkg;

  localparam int DATA_W = 8;
  localparam int CG_AW  = 6;
  localparam int DD_AW  = 7;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_CG,
    OP_SET_DD,
    OP_ENTRY,
    OP_WRITE
  } ac_op_e;

  typedef struct packed {
    logic              rs;
    logic              rw;
    logic [DATA_W-1:0] data;
  } bus_req_t;

  // Glyph space: plain modulo-64 step.
  function automatic logic [CG_AW-1:0] cg_step(input logic [CG_AW-1:0] a,
                                               input logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  // Character space: two rows of lc cells, second row starting at l2.
  function automatic logic [DD_AW-1:0] dd_step(input logic [DD_AW-1:0] a,
                                               input logic up,
                                               input int lc,
                                               input int l2);
    logic [DD_AW-1:0] r1_last, r2_first, r2_last;
    r1_last  = DD_AW'(lc - 1);
    r2_first = DD_AW'(l2);
    r2_last  = DD_AW'(l2 + lc - 1);
    if (up) begin
      if (a == r1_last)      return r2_first;
      else if (a == r2_last) return '0;
      else                   return a + 1'b1;
    end else begin
      if (a == r2_first)     return r1_last;
      else if (a == '0)      return r2_last;
      else                   return a - 1'b1;
    end
  endfunction

endpackage

// File: rtl/char_ac_strobe_sync.sv
`timescale 1ns/1ps
module char_ac_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_async,
  output logic fall_pulse
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= en_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign fall_pulse = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/char_ac_decode.sv
`timescale 1ns/1ps
module char_ac_decode
  import char_ac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  bus_req_t          req,
  output ac_op_e            op,
  output logic [DD_AW-1:0]  load_val,
  output logic              dir_up,
  output logic [DATA_W-1:0] wdata
);

  bus_req_t req_q;
  logic     vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) req_q <= req;
    end
  end

  always_comb begin
    op = OP_NONE;
    if (vld_q && !req_q.rw) begin
      if (req_q.rs)                                  op = OP_WRITE;
      else if (req_q.data[7])                        op = OP_SET_DD;
      else if (req_q.data[6])                        op = OP_SET_CG;
      else if (req_q.data[DATA_W-1:2] == 6'b000001)  op = OP_ENTRY;
    end
  end

  always_comb begin
    if (req_q.data[7]) load_val = req_q.data[DD_AW-1:0];
    else               load_val = DD_AW'(req_q.data[CG_AW-1:0]);
  end

  assign dir_up = req_q.data[1];
  assign wdata  = req_q.data;

endmodule

// File: rtl/char_ac_counter.sv
`timescale 1ns/1ps
module char_ac_counter
  import char_ac_pkg::*;
#(
  parameter int LINE_CHARS = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ac_op_e           op,
  input  logic [DD_AW-1:0] load_val,
  input  logic             dir_up,
  output logic [DD_AW-1:0] ac,
  output logic             tgt_cg,
  output logic             inc
);

  logic [DD_AW-1:0] ac_step;

  always_comb begin
    if (tgt_cg) ac_step = DD_AW'(cg_step(ac[CG_AW-1:0], inc));
    else        ac_step = dd_step(ac, inc, LINE_CHARS, LINE2_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac     <= '0;
      tgt_cg <= 1'b0;
      inc    <= 1'b1;
    end else begin
      unique case (op)
        OP_SET_CG: begin ac <= load_val; tgt_cg <= 1'b1; end
        OP_SET_DD: begin ac <= load_val; tgt_cg <= 1'b0; end
        OP_ENTRY:  inc <= dir_up;
        OP_WRITE:  ac  <= ac_step;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/char_ac_wport.sv
`timescale 1ns/1ps
module char_ac_wport
  import char_ac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              tgt_cg,
  input  logic [DD_AW-1:0]  ac,
  input  logic [DATA_W-1:0] wdata,
  output logic              cg_we,
  output logic [CG_AW-1:0]  cg_addr,
  output logic [DATA_W-1:0] cg_wdata,
  output logic              dd_we,
  output logic [DD_AW-1:0]  dd_addr,
  output logic [DATA_W-1:0] dd_wdata
);

  logic cg_go, dd_go;
  assign cg_go = wr_go &  tgt_cg;
  assign dd_go = wr_go & ~tgt_cg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cg_we    <= 1'b0;
      cg_addr  <= '0;
      cg_wdata <= '0;
    end else begin
      cg_we <= cg_go;
      if (cg_go) begin
        cg_addr  <= ac[CG_AW-1:0];
        cg_wdata <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_we    <= 1'b0;
      dd_addr  <= '0;
      dd_wdata <= '0;
    end else begin
      dd_we <= dd_go;
      if (dd_go) begin
        dd_addr  <= ac;
        dd_wdata <= wdata;
      end
    end
  end

endmodule

// File: rtl/char_ac_core.sv
`timescale 1ns/1ps
module char_ac_core
  import char_ac_pkg::*;
#(
  parameter int LINE_CHARS  = 40,
  parameter int LINE2_BASE  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_rs,
  input  logic              host_rw,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              cg_we,
  output logic [CG_AW-1:0]  cg_addr,
  output logic [DATA_W-1:0] cg_wdata,
  output logic              dd_we,
  output logic [DD_AW-1:0]  dd_addr,
  output logic [DATA_W-1:0] dd_wdata
);

  // Named internal events, visible to the bound checker.
  logic              take_evt;
  logic              wr_evt;
  ac_op_e            op;
  logic [DD_AW-1:0]  load_val;
  logic              dir_up;
  logic [DATA_W-1:0] wdata;
  logic [DD_AW-1:0]  ac_q;
  logic              tgt_cg;
  logic              inc;
  bus_req_t          req;

  assign req = '{rs: host_rs, rw: host_rw, data: host_din};

  char_ac_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_async   (host_en),
    .fall_pulse (take_evt)
  );

  char_ac_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take_evt),
    .req      (req),
    .op       (op),
    .load_val (load_val),
    .dir_up   (dir_up),
    .wdata    (wdata)
  );

  char_ac_counter #(.LINE_CHARS(LINE_CHARS), .LINE2_BASE(LINE2_BASE)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .load_val (load_val),
    .dir_up   (dir_up),
    .ac       (ac_q),
    .tgt_cg   (tgt_cg),
    .inc      (inc)
  );

  assign wr_evt = (op == OP_WRITE);

  char_ac_wport u_wp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_go    (wr_evt),
    .tgt_cg   (tgt_cg),
    .ac       (ac_q),
    .wdata    (wdata),
    .cg_we    (cg_we),
    .cg_addr  (cg_addr),
    .cg_wdata (cg_wdata),
    .dd_we    (dd_we),
    .dd_addr  (dd_addr),
    .dd_wdata (dd_wdata)
  );

  // Busy bit is never set: the core completes every transfer in fixed cycles.
  assign host_dout = {1'b0, ac_q};

endmodule

// File: rtl/char_ac_checker.sv
`timescale 1ns/1ps
module char_ac_checker #(
  parameter int LINE_CHARS = 40,
  parameter int LINE2_BASE = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_evt,
  input logic       tgt_cg,
  input logic       inc,
  input logic [6:0] ac,
  input logic [1:0] rd_hi,
  input logic       cg_we,
  input logic [5:0] cg_addr,
  input logic       dd_we,
  input logic [6:0] dd_addr
);

  function automatic logic in_rows(input logic [6:0] a);
    return (int'(a) < LINE_CHARS) ||
           ((int'(a) >= LINE2_BASE) && (int'(a) < LINE2_BASE + LINE_CHARS));
  endfunction

  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cg_we, dd_we}));

  p_cg_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && tgt_cg |=> cg_we && (cg_addr == $past(ac[5:0])));

  p_dd_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && !tgt_cg |=> dd_we && (dd_addr == $past(ac)));

  p_cg_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cg_we |=> !cg_we);

  p_dd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dd_we |=> !dd_we);

  p_cg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_we |=> cg_we || $stable(cg_addr));

  p_busy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi[1] == 1'b0);

  p_cg_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cg |-> rd_hi[0] == 1'b0);

  p_cg_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && tgt_cg && inc && (ac[5:0] == 6'h3F) |=> ac == 7'h00);

  p_dd_rows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt && !tgt_cg && in_rows(ac) |=> in_rows(ac));

endmodule

bind char_ac_core char_ac_checker #(
  .LINE_CHARS (LINE_CHARS),
  .LINE2_BASE (LINE2_BASE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_evt  (wr_evt),
  .tgt_cg  (tgt_cg),
  .inc     (inc),
  .ac      (ac_q),
  .rd_hi   (host_dout[7:6]),
  .cg_we   (cg_we),
  .cg_addr (cg_addr),
  .dd_we   (dd_we),
  .dd_addr (dd_addr)
);

// File: tb/char_ac_core_bench.sv
`timescale 1ns/1ps
module char_ac_core_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, host_en, host_rs, host_rw;
  logic [7:0] host_din, host_dout;
  logic       cg_we, dd_we;
  logic [5:0] cg_addr;
  logic [6:0] dd_addr;
  logic [7:0] cg_wdata, dd_wdata;

  char_ac_core u_char_ac_core (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_rs(host_rs),
    .host_rw(host_rw), .host_din(host_din), .host_dout(host_dout),
    .cg_we(cg_we), .cg_addr(cg_addr), .cg_wdata(cg_wdata),
    .dd_we(dd_we), .dd_addr(dd_addr), .dd_wdata(dd_wdata)
  );

  int n_chk = 0;
  int n_err = 0;

  // Write-port monitor, sampled 1 ns after the edge.
  int         cg_cnt = 0, dd_cnt = 0;
  logic [6:0] cg_la, dd_la;
  logic [7:0] cg_ld, dd_ld;
  logic [7:0] ram_cg [64];
  logic [7:0] ram_dd [128];

  always @(posedge clk) begin
    #1;
    if (cg_we) begin
      cg_cnt++; cg_la = {1'b0, cg_addr}; cg_ld = cg_wdata; ram_cg[cg_addr] = cg_wdata;
    end
    if (dd_we) begin
      dd_cnt++; dd_la = dd_addr; dd_ld = dd_wdata; ram_dd[dd_addr] = dd_wdata;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic rs, input logic rw, input logic [7:0] d);
    @(negedge clk);
    host_rs = rs; host_rw = rw; host_din = d; host_en = 1'b1;
    repeat (3) @(negedge clk);
    host_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic read_ac(output logic [7:0] v);
    @(negedge clk);
    host_rs = 1'b0; host_rw = 1'b1; host_din = 8'h00; host_en = 1'b1;
    repeat (3) @(negedge clk);
    v = host_dout;
    host_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // {rs, rw, data, expected counter, port (0 none, 1 glyph, 2 char), write address}
  localparam int NV = 21;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hA6, 7'h26, 2'd0, 7'h00},  // R4 load 26
    {1'b1, 1'b0, 8'h41, 7'h27, 2'd2, 7'h26},  // R7 R8
    {1'b1, 1'b0, 8'h42, 7'h40, 2'd2, 7'h27},  // R5 27->40
    {1'b0, 1'b0, 8'hE7, 7'h67, 2'd0, 7'h00},  // R4 load 67
    {1'b1, 1'b0, 8'h43, 7'h00, 2'd2, 7'h67},  // R5 67->00
    {1'b0, 1'b0, 8'h04, 7'h00, 2'd0, 7'h00},  // R9 decrement
    {1'b1, 1'b0, 8'h44, 7'h67, 2'd2, 7'h00},  // R5 00->67
    {1'b0, 1'b0, 8'hC0, 7'h40, 2'd0, 7'h00},  // R4 load 40
    {1'b1, 1'b0, 8'h45, 7'h27, 2'd2, 7'h40},  // R5 40->27
    {1'b0, 1'b0, 8'h41, 7'h01, 2'd0, 7'h00},  // R2 glyph 01
    {1'b1, 1'b0, 8'h46, 7'h00, 2'd1, 7'h01},  // R7 glyph write
    {1'b1, 1'b0, 8'h47, 7'h3F, 2'd1, 7'h00},  // R3 00->3F
    {1'b0, 1'b0, 8'h06, 7'h3F, 2'd0, 7'h00},  // R9 increment
    {1'b1, 1'b0, 8'h48, 7'h00, 2'd1, 7'h3F},  // R3 3F->00
    {1'b1, 1'b1, 8'h55, 7'h00, 2'd0, 7'h00},  // R10 data read
    {1'b0, 1'b0, 8'h01, 7'h00, 2'd0, 7'h00},  // R10 other code
    {1'b0, 1'b0, 8'h3C, 7'h00, 2'd0, 7'h00},  // R10 near entry code
    {1'b1, 1'b0, 8'h49, 7'h01, 2'd1, 7'h00},  // R10 target and direction kept
    {1'b0, 1'b1, 8'h00, 7'h01, 2'd0, 7'h00},  // R10 status read
    {1'b0, 1'b0, 8'h7F, 7'h3F, 2'd0, 7'h00},  // R2 load 3F
    {1'b1, 1'b0, 8'h4A, 7'h00, 2'd1, 7'h3F}   // R3 wrap
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; host_en = 1'b0; host_rs = 1'b0; host_rw = 1'b0; host_din = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(host_dout == 8'h00, "R1 readback", host_dout, 8'h00);
    check(!cg_we && !dd_we, "R1 strobes", {cg_we, dd_we}, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      cg_cnt = 0; dd_cnt = 0;
      bus_op(v[25], v[24], v[23:16]);
      check(cg_cnt == (v[8:7] == 2'd1 ? 1 : 0), "R7 R11 glyph strobe count", cg_cnt, v[8:7]);
      check(dd_cnt == (v[8:7] == 2'd2 ? 1 : 0), "R7 R11 char strobe count", dd_cnt, v[8:7]);
      if (v[8:7] == 2'd1) begin
        check(cg_la == v[6:0] && cg_ld == v[23:16], "R7 glyph addr/data", {cg_la, cg_ld}, {v[6:0], v[23:16]});
        check({1'b0, cg_addr} == v[6:0] && cg_wdata == v[23:16], "R11 glyph hold", {cg_addr, cg_wdata}, {v[6:0], v[23:16]});
      end
      if (v[8:7] == 2'd2) begin
        check(dd_la == v[6:0] && dd_ld == v[23:16], "R7 char addr/data", {dd_la, dd_ld}, {v[6:0], v[23:16]});
        check(dd_addr == v[6:0] && dd_wdata == v[23:16], "R11 char hold", {dd_addr, dd_wdata}, {v[6:0], v[23:16]});
      end
      read_ac(rd);
      check(rd == {1'b0, v[15:9]}, "R6 R8 counter readback", rd, {1'b0, v[15:9]});
    end
    check(ram_dd[7'h67] == 8'h43 && ram_dd[7'h40] == 8'h45, "R7 char RAM contents",
          {ram_dd[7'h67], ram_dd[7'h40]}, 16'h4345);
    check(ram_cg[6'h3F] == 8'h4A && ram_cg[6'h00] == 8'h49, "R7 glyph RAM contents",
          {ram_cg[6'h3F], ram_cg[6'h00]}, 16'h4A49);

    // R3: 65 glyph writes from 00, increment
    bus_op(1'b0, 1'b0, 8'h40);
    bus_op(1'b0, 1'b0, 8'h06);
    for (int k = 0; k < 65; k++) begin
      cg_cnt = 0;
      bus_op(1'b1, 1'b0, 8'(k) ^ 8'hA5);
      check(cg_cnt == 1 && cg_la == 7'(k % 64), "R3 glyph walk address", cg_la, k % 64);
    end
    read_ac(rd);
    check(rd == 8'h01, "R3 glyph wrap readback", rd, 8'h01);
    check(ram_cg[0] == 8'hE5, "R3 glyph overwrite", ram_cg[0], 8'hE5);

    // R5: 80 character writes from 00, decrement
    bus_op(1'b0, 1'b0, 8'h80);
    bus_op(1'b0, 1'b0, 8'h04);
    for (int k = 0; k < 80; k++) begin
      int p;
      logic [6:0] ea;
      p  = (80 - k) % 80;
      ea = (p < 40) ? 7'(p) : 7'(64 + p - 40);
      dd_cnt = 0;
      bus_op(1'b1, 1'b0, 8'(k));
      check(dd_cnt == 1 && dd_la == ea, "R5 decrement walk address", dd_la, ea);
    end
    read_ac(rd);
    check(rd == 8'h00, "R5 walk returns to 00", rd, 8'h00);

    // R1: reset from glyph mode with decrement
    bus_op(1'b0, 1'b0, 8'h55);
    bus_op(1'b0, 1'b0, 8'h04);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(host_dout == 8'h00, "R1 readback after reset", host_dout, 8'h00);
    dd_cnt = 0; cg_cnt = 0;
    bus_op(1'b1, 1'b0, 8'h77);
    check(dd_cnt == 1 && cg_cnt == 0 && dd_la == 7'h00, "R1 target is char RAM", {cg_cnt[3:0], dd_la}, 0);
    read_ac(rd);
    check(rd == 8'h01, "R1 direction is increment", rd, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule